// File: doc/BRIEF.md
# Dual-Clock FIFO with Ready Flags

A first-in first-out buffer whose producer side and consumer side each run on their own free-running clock. The two clocks may have no phase or frequency relation. A word moves on a rising clock edge only when that side's enable is high and that side's ready flag is high. No gated clock is needed for single transfers.

Raw full and empty levels are not brought out. The write side sees an active-high input-ready flag that says a word can be taken. The read side sees an active-high output-ready flag that says a word is waiting. Each flag is computed in the clock domain that uses it. The input is the opposite side's Gray-coded pointer, passed through a two-flop synchronizer. Because of that latency, a flag can stay not-ready for a few extra cycles after the real state has changed. It never shows ready when the real state is not ready.

Read data is held in a register that is loaded on the read-clock edge that accepts a read. Depth is a power of two, at least 4, with a default of 16. Width is a parameter with a default of 32. A single active-high reset is sampled synchronously in each domain. It must be held for at least three cycles of the slower clock.

Top module: `dcfifo_rdy`

## Requirements
- R1: A word on `wr_data` is stored when `wr_en` and `in_rdy` are both high at a rising `wr_clk` edge. Words are read out with the same values and in the same order in which they were accepted.
- R2: When `rd_en` and `out_rdy` are both high at a rising `rd_clk` edge, `rd_data` takes the oldest stored word at that edge.
- R3: A read request while `out_rdy` is low, or a cycle with `rd_en` low, leaves `rd_data` and the read pointer unchanged.
- R4: A write request while `in_rdy` is low is dropped. No stored word is overwritten and the write pointer does not move.
- R5: `in_rdy` is never high while DEPTH words are stored, so the buffer never overflows.
- R6: `out_rdy` is never high while the buffer holds no word, so the buffer never underflows.
- R7: Once both sides go idle, within 4 cycles of the destination clock, `in_rdy` is high exactly when fewer than DEPTH words are stored and `out_rdy` is high exactly when at least one word is stored.
- R8: Each pointer crosses to the other domain as a Gray code, and at most one bit of it changes per source-clock edge.
- R9: While `rst` is high, both flags are low. One `wr_clk` cycle after reset is released, `in_rdy` is high. `out_rdy` stays low until a word is written.
- R10: The buffer holds exactly DEPTH words. After DEPTH accepted writes with no reads, `in_rdy` goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Free-running write-side clock |
| rst | input | 1 | Active-high reset, sampled in each domain |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| in_rdy | output | 1 | High when a word can be accepted (write domain) |
| rd_clk | input | 1 | Free-running read-side clock |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered word from the last accepted read |
| out_rdy | output | 1 | High when a word can be read (read domain) |

## Verification
The properties assume that `rst` is asserted at time zero and is held across several edges of both clocks. They also assume that the enables and write data change only away from the rising edge of their own clock. The stimulus drives every input on the falling edge of its own clock and holds reset for eight cycles of the slower clock. The two clock periods share no common factor, so the pointer crossings sample at drifting phases. The no-overflow and no-underflow properties compare each side's own pointer with the synchronized copy of the other side's pointer. They rely on that copy only lagging, never leading, the true pointer.

// File: rtl/afifo_pkg.sv
`timescale 1ns/1ps
package afifo_pkg;

    // Widest pointer the helpers handle; callers zero-extend into it.
    localparam int PTR_MAX = 32;

    typedef logic [PTR_MAX-1:0] ptr_word_t;

    // Binary to reflected Gray code.
    function automatic ptr_word_t to_gray(ptr_word_t b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary.
    function automatic ptr_word_t from_gray(ptr_word_t g);
        ptr_word_t b;
        b[PTR_MAX-1] = g[PTR_MAX-1];
        for (int i = PTR_MAX - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/afifo_sync2.sv
`timescale 1ns/1ps
// Two cascaded flops in the destination clock domain.
module afifo_sync2 #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= din;
            stage2_q <= stage1_q;
        end
    end

    assign dout = stage2_q;
endmodule

// File: rtl/afifo_wr_side.sv
`timescale 1ns/1ps
// Write-domain pointer and input-ready flag.
module afifo_wr_side
    import afifo_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW:0]   rgray_sync,
    output logic          in_rdy,
    output logic          fire,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wbin,
    output logic [AW:0]   wgray
);
    localparam int PW = AW + 1;

    logic [PW-1:0] wbin_q, wbin_d;
    logic [PW-1:0] wgray_q, wgray_d;
    logic [PW-1:0] full_pat;
    logic          rdy_q;
    logic          full_d;

    assign fire    = wr_en & rdy_q;
    assign wbin_d  = wbin_q + PW'(fire);
    assign wgray_d = PW'(to_gray(ptr_word_t'(wbin_d)));

    // Full: the write pointer is one lap ahead of the read pointer.
    // In Gray code that means the top two bits differ and the rest match.
    assign full_pat = {~rgray_sync[PW-1:PW-2], rgray_sync[PW-3:0]};
    assign full_d   = (wgray_d == full_pat);

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin_q  <= '0;
            wgray_q <= '0;
            rdy_q   <= 1'b0;
        end else begin
            wbin_q  <= wbin_d;
            wgray_q <= wgray_d;
            rdy_q   <= ~full_d;
        end
    end

    assign in_rdy = rdy_q;
    assign waddr  = wbin_q[AW-1:0];
    assign wbin   = wbin_q;
    assign wgray  = wgray_q;
endmodule

// File: rtl/afifo_rd_side.sv
`timescale 1ns/1ps
// Read-domain pointer and output-ready flag.
module afifo_rd_side
    import afifo_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [AW:0]   wgray_sync,
    output logic          out_rdy,
    output logic          fire,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rbin,
    output logic [AW:0]   rgray
);
    localparam int PW = AW + 1;

    logic [PW-1:0] rbin_q, rbin_d;
    logic [PW-1:0] rgray_q, rgray_d;
    logic          rdy_q;
    logic          empty_d;

    assign fire    = rd_en & rdy_q;
    assign rbin_d  = rbin_q + PW'(fire);
    assign rgray_d = PW'(to_gray(ptr_word_t'(rbin_d)));
    assign empty_d = (rgray_d == wgray_sync);

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin_q  <= '0;
            rgray_q <= '0;
            rdy_q   <= 1'b0;
        end else begin
            rbin_q  <= rbin_d;
            rgray_q <= rgray_d;
            rdy_q   <= ~empty_d;
        end
    end

    assign out_rdy = rdy_q;
    assign raddr   = rbin_q[AW-1:0];
    assign rbin    = rbin_q;
    assign rgray   = rgray_q;
endmodule

// File: rtl/afifo_ram.sv
`timescale 1ns/1ps
// Storage: written on the write clock, registered read on the read clock.
module afifo_ram #(
    parameter int DATA_W = 32,
    parameter int AW     = 4
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              rst,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (re) begin
            rdata_q <= mem[raddr];
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/dcfifo_rdy.sv
`timescale 1ns/1ps
// Dual-clock FIFO with synchronized ready flags.
module dcfifo_rdy #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              wr_clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              in_rdy,
    input  logic              rd_clk,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              out_rdy
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          wr_fire, rd_fire;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [PW-1:0] wr_bin, rd_bin;
    logic [PW-1:0] wr_gray, rd_gray;
    logic [PW-1:0] rgray_ws;  // read pointer seen in the write domain
    logic [PW-1:0] wgray_rs;  // write pointer seen in the read domain

    afifo_wr_side #(.AW(AW)) u_wr (
        .clk        (wr_clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .rgray_sync (rgray_ws),
        .in_rdy     (in_rdy),
        .fire       (wr_fire),
        .waddr      (wr_addr),
        .wbin       (wr_bin),
        .wgray      (wr_gray)
    );

    afifo_rd_side #(.AW(AW)) u_rd (
        .clk        (rd_clk),
        .rst        (rst),
        .rd_en      (rd_en),
        .wgray_sync (wgray_rs),
        .out_rdy    (out_rdy),
        .fire       (rd_fire),
        .raddr      (rd_addr),
        .rbin       (rd_bin),
        .rgray      (rd_gray)
    );

    afifo_sync2 #(.W(PW)) u_sync_r2w (
        .clk  (wr_clk),
        .rst  (rst),
        .din  (rd_gray),
        .dout (rgray_ws)
    );

    afifo_sync2 #(.W(PW)) u_sync_w2r (
        .clk  (rd_clk),
        .rst  (rst),
        .din  (wr_gray),
        .dout (wgray_rs)
    );

    afifo_ram #(.DATA_W(DATA_W), .AW(AW)) u_ram (
        .wclk  (wr_clk),
        .we    (wr_fire),
        .waddr (wr_addr),
        .wdata (wr_data),
        .rclk  (rd_clk),
        .rst   (rst),
        .re    (rd_fire),
        .raddr (rd_addr),
        .rdata (rd_data)
    );
endmodule

// File: rtl/dcfifo_rdy_chk.sv
`timescale 1ns/1ps
module dcfifo_rdy_chk
    import afifo_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input logic                      wr_clk,
    input logic                      rd_clk,
    input logic                      rst,
    input logic                      wr_en,
    input logic                      rd_en,
    input logic                      in_rdy,
    input logic                      out_rdy,
    input logic [DATA_W-1:0]         rd_data,
    input logic [$clog2(DEPTH):0]    wr_bin,
    input logic [$clog2(DEPTH):0]    rd_bin,
    input logic [$clog2(DEPTH):0]    wr_gray,
    input logic [$clog2(DEPTH):0]    rd_gray,
    input logic [$clog2(DEPTH):0]    rgray_ws,
    input logic [$clog2(DEPTH):0]    wgray_rs
);
    localparam int PW = $clog2(DEPTH) + 1;

    logic [PW-1:0] occ_w;
    logic [PW-1:0] wbin_rs;

    assign occ_w   = wr_bin - PW'(from_gray(ptr_word_t'(rgray_ws)));
    assign wbin_rs = PW'(from_gray(ptr_word_t'(wgray_rs)));

    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (rst)
        in_rdy |-> (occ_w < PW'(DEPTH))); // R5

    AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (rst)
        out_rdy |-> (rd_bin != wbin_rs)); // R6

    AST_RD_DATA_HOLD: assert property (@(posedge rd_clk) disable iff (rst)
        !(rd_en && out_rdy) |=> $stable(rd_data)); // R3

    AST_RD_PTR_HOLD: assert property (@(posedge rd_clk) disable iff (rst)
        !(rd_en && out_rdy) |=> $stable(rd_bin)); // R3

    AST_WR_PTR_HOLD: assert property (@(posedge wr_clk) disable iff (rst)
        !(wr_en && in_rdy) |=> $stable(wr_bin)); // R4

    AST_WR_GRAY_STEP: assert property (@(posedge wr_clk) disable iff (rst)
        $countones(wr_gray ^ $past(wr_gray)) <= 1); // R8

    AST_RD_GRAY_STEP: assert property (@(posedge rd_clk) disable iff (rst)
        $countones(rd_gray ^ $past(rd_gray)) <= 1); // R8
endmodule

bind dcfifo_rdy dcfifo_rdy_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .wr_clk   (wr_clk),
    .rd_clk   (rd_clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .in_rdy   (in_rdy),
    .out_rdy  (out_rdy),
    .rd_data  (rd_data),
    .wr_bin   (wr_bin),
    .rd_bin   (rd_bin),
    .wr_gray  (wr_gray),
    .rd_gray  (rd_gray),
    .rgray_ws (rgray_ws),
    .wgray_rs (wgray_rs)
);

// File: tb/test_dcfifo_rdy.sv
`timescale 1ns/1ps
module test_dcfifo_rdy;
    localparam int DATA_W = 32;
    localparam int DEPTH  = 16;

    logic              wr_clk = 1'b0;
    logic              rd_clk = 1'b0;
    logic              rst    = 1'b1;
    logic              wr_en  = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              rd_en  = 1'b0;
    logic              in_rdy, out_rdy;
    logic [DATA_W-1:0] rd_data;

    always #2.5 wr_clk = ~wr_clk;   // 200 MHz
    always #3.5 rd_clk = ~rd_clk;   // unrelated read clock

    dcfifo_rdy #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_dcfifo_rdy (
        .wr_clk (wr_clk), .rst (rst), .wr_en (wr_en), .wr_data (wr_data),
        .in_rdy (in_rdy), .rd_clk (rd_clk), .rd_en (rd_en),
        .rd_data (rd_data), .out_rdy (out_rdy)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int wr_pct = 0;
    int rd_pct = 0;
    int n_ign  = 0;
    logic [DATA_W-1:0] model_q[$];
    logic [DATA_W-1:0] exp_word;
    logic [DATA_W-1:0] last_rd = '0;
    bit rd_pend = 0;
    int seed_dummy;

    function automatic bit exp_in_rdy(int stored);
        return stored < DEPTH;
    endfunction

    function automatic bit exp_out_rdy(int stored);
        return stored > 0;
    endfunction

    task automatic check(bit ok, string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Write-side driver and model update, on the falling write edge.
    always @(negedge wr_clk) begin
        if (rst) begin
            wr_en = 1'b0;
        end else begin
            wr_en   = (($urandom % 100) < wr_pct);
            wr_data = $urandom;
            if (wr_en && in_rdy) begin
                // R5: accepting while the model already holds DEPTH words
                check(model_q.size() < DEPTH, "R5 overflow", 32'(model_q.size()), 32'(DEPTH - 1));
                model_q.push_back(wr_data);
            end else if (wr_en) begin
                n_ign++;
            end
        end
    end

    // Read-side driver and data compare, on the falling read edge.
    always @(negedge rd_clk) begin
        if (rst) begin
            rd_en   = 1'b0;
            rd_pend = 0;
            last_rd = '0;
        end else begin
            if (rd_pend) begin
                check(rd_data == exp_word, "R1/R2 read data", rd_data, exp_word);
                rd_pend = 0;
            end else begin
                check(rd_data == last_rd, "R3 data held", rd_data, last_rd);
            end
            last_rd = rd_data;
            rd_en = (($urandom % 100) < rd_pct);
            if (rd_en && out_rdy) begin
                check(model_q.size() > 0, "R6 underflow", 32'(model_q.size()), 32'd1);
                if (model_q.size() > 0) begin
                    exp_word = model_q.pop_front();
                    rd_pend  = 1;
                end
            end
        end
    end

    task automatic settle_and_check(string tag);
        wr_pct = 0;
        rd_pct = 0;
        repeat (8) @(negedge rd_clk);
        @(negedge wr_clk);
        check(in_rdy == exp_in_rdy(model_q.size()), {"R7 in_rdy ", tag},
              32'(in_rdy), 32'(exp_in_rdy(model_q.size())));
        @(negedge rd_clk);
        check(out_rdy == exp_out_rdy(model_q.size()), {"R7 out_rdy ", tag},
              32'(out_rdy), 32'(exp_out_rdy(model_q.size())));
    endtask

    task automatic run_seq();
        // R9: flags low during reset
        repeat (8) @(negedge rd_clk);
        check(in_rdy == 1'b0, "R9 in_rdy in reset", 32'(in_rdy), 32'd0);
        check(out_rdy == 1'b0, "R9 out_rdy in reset", 32'(out_rdy), 32'd0);
        @(negedge wr_clk);
        rst = 1'b0;
        @(negedge wr_clk);
        @(negedge wr_clk);
        check(in_rdy == 1'b1, "R9 in_rdy after reset", 32'(in_rdy), 32'd1);
        check(out_rdy == 1'b0, "R9 out_rdy after reset", 32'(out_rdy), 32'd0);

        // R10 / R4: fill, then keep pushing while full
        wr_pct = 100;
        repeat (60) @(negedge wr_clk);
        settle_and_check("full");
        check(model_q.size() == DEPTH, "R10 capacity", 32'(model_q.size()), 32'(DEPTH));
        check(in_rdy == 1'b0, "R10 in_rdy low when full", 32'(in_rdy), 32'd0);
        check(n_ign > 0, "R4 writes attempted while full", 32'(n_ign), 32'd1);

        // Drain fully, keep requesting reads while empty (R3, R4 via data)
        rd_pct = 100;
        repeat (60) @(negedge rd_clk);
        settle_and_check("drained");
        check(model_q.size() == 0, "R4 no extra word stored", 32'(model_q.size()), 32'd0);

        // Random traffic at several balances
        for (int ph = 0; ph < 4; ph++) begin
            case (ph)
                0: begin wr_pct = 50; rd_pct = 50; end
                1: begin wr_pct = 90; rd_pct = 30; end
                2: begin wr_pct = 25; rd_pct = 85; end
                default: begin wr_pct = 70; rd_pct = 70; end
            endcase
            repeat (3000) @(negedge wr_clk);
            settle_and_check("random");
        end

        // Final drain
        rd_pct = 100;
        repeat (80) @(negedge rd_clk);
        settle_and_check("final");
        check(model_q.size() == 0, "R1 all words returned", 32'(model_q.size()), 32'd0);
        repeat (4) @(negedge rd_clk);
    endtask

    initial begin
        seed_dummy = $urandom(32'h1f2e3d4c);
        fork
            run_seq();
            begin
                repeat (150000) @(posedge wr_clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog expired at %0t", $time);
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule